// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block programs single words, erases 64-word pages and erases the whole array of an on-chip flash array. The array is modelled as registers, and its depth is set by a parameter. Software drives the block through one write port that selects among four registers: an unlock key, a command, a program-data register and a word address. Each program or erase must be unlocked first. Software writes the key value 0xA5C3, and the next command consumes it. A command issued without the key does nothing and raises an error flag.

Program data goes into a two-entry buffer together with the address that is current when the data is written. The address register then steps forward by one, so consecutive words can be loaded without rewriting it. While one word's program pulse runs, the next word waits in the buffer and starts on the cycle its predecessor finishes. A write to the data register while both entries are occupied is refused.

Pulse lengths are given in clock cycles, so a fast clock or a short simulation only needs different parameter values. The busy output covers the whole of every operation, and reads of the array are refused while it is high. Programming can only clear bits. Erasing sets every affected bit to one.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the block is idle: busy, buf_full and cmd_err are low, and every array word reads 0xFFFF.
- R2: A command is accepted only if the last key-register write (reg_sel 00) carried 0xA5C3. Any command-register write (reg_sel 01) made while idle consumes the key, whether or not it is accepted. A key write with any other value disarms the block.
- R3: The command code is reg_wdata[1:0]: 01 program, 10 page erase, 11 mass erase, 00 invalid. A command that arrives while idle, unkeyed or with code 00, is ignored and sets cmd_err. The next accepted command clears cmd_err.
- R4: A write to the data register (reg_sel 10) stores the data together with the address register (reg_sel 11, bits ADDR_W-1:0), then increments the address. The buffer holds two words and buf_full is high while it does. A data write made while full is dropped, and the address does not advance.
- R5: Programming a word stores old AND new, so bits only go from 1 to 0. The first buffered word starts one cycle after the command and takes PROG_CYC cycles. With one word buffered, busy lasts PROG_CYC+1 cycles.
- R6: When a pulse ends and another word is buffered, that word starts on the same edge. n buffered words keep busy high for n*PROG_CYC+1 cycles.
- R7: Program mode ends when a pulse ends with the buffer empty. If the program command finds the buffer empty, busy stays high until a word arrives and has been programmed.
- R8: Page erase sets to 0xFFFF all words whose address bits above bit PAGE_W-1 equal those of the address register. Words outside that page are unchanged. Busy lasts PAGE_CYC cycles.
- R9: Mass erase sets every word to 0xFFFF. Busy lasts MASS_CYC cycles.
- R10: With rd_en high while not busy, rd_ok is high one cycle later and rd_data holds the word at rd_addr. With rd_en high while busy, rd_ok and rd_data are zero one cycle later.
- R11: A command written while busy is ignored: it sets no error and leaves the key armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 00 key, 01 command, 10 data, 11 address |
| reg_wdata | input | 16 | Register write data |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read word address |
| rd_data | output | 16 | Read word, one cycle after rd_en |
| rd_ok | output | 1 | Read was served (not blocked) |
| busy | output | 1 | An operation is in progress |
| buf_full | output | 1 | Both data buffer entries occupied |
| cmd_err | output | 1 | Last idle command was rejected |

## Verification
The assertions assume that at most one register is written per cycle and that rd_addr always falls inside the array. The bench writes registers through a task that raises one strobe for one cycle, and it uses addresses below the default depth only. The assertions also assume that pulse parameters are at least one cycle. The bench keeps them short but non-zero. It lets the reference model decide when a write lands in a busy or full window, and it steers some writes into those windows on purpose.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'b00,
    SEL_CMD  = 2'b01,
    SEL_DATA = 2'b10,
    SEL_ADDR = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_PAGE = 2'b10,
    OP_MASS = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE
  } seq_st_e;

  // Programming can only pull bits low.
  function automatic logic [WORD_W-1:0] prog_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate import flash_seq_pkg::*; #(
  parameter logic [WORD_W-1:0] KEY_VAL = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [WORD_W-1:0] key_data,
  input  logic              cmd_wr,
  input  op_e               cmd_op,
  input  logic              busy_i,
  output logic              cmd_accept,
  output logic              cmd_err
);
  logic armed;
  logic cmd_reject;

  assign cmd_accept = cmd_wr && !busy_i && armed && (cmd_op != OP_NONE);
  assign cmd_reject = cmd_wr && !busy_i && !cmd_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      if (key_wr)
        armed <= (key_data == KEY_VAL);
      else if (cmd_wr && !busy_i)
        armed <= 1'b0;
      if (cmd_accept)
        cmd_err <= 1'b0;
      else if (cmd_reject)
        cmd_err <= 1'b1;
    end
  end

  // R11
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy_i) |=> $stable(armed) && $stable(cmd_err));
  // R2
  key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !armed && !cmd_err);
endmodule

// File: rtl/flash_word_buffer.sv
module flash_word_buffer #(
  parameter int ENT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  output logic             push_ok,
  output logic [ENT_W-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int DEPTH = 2;

  logic [ENT_W-1:0] slot0, slot1;
  logic [1:0]       count;
  logic             pop_do;

  assign empty   = (count == 2'd0);
  assign full    = (count == 2'(DEPTH));
  assign push_ok = push && !full;
  assign pop_do  = pop && !empty;
  assign head    = slot0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      count <= '0;
    end else begin
      unique case ({push_ok, pop_do})
        2'b10: begin
          if (count == 2'd0) slot0 <= push_data;
          else               slot1 <= push_data;
          count <= count + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          count <= count - 2'd1;
        end
        2'b11: slot0 <= push_data;
        default: ;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'(DEPTH));
  // R4
  refused_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full && $stable(slot1));
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5
  pulse_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !active);
endmodule

// File: rtl/flash_array.sv
module flash_array import flash_seq_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_we,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [WORD_W-1:0]        prog_data,
  input  logic                     erase_we,
  input  logic                     erase_all,
  input  logic [ADDR_W-PAGE_W-1:0] erase_page,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     blocked,
  output logic [WORD_W-1:0]        rd_data,
  output logic                     rd_ok
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] old_at_prog;

  assign old_at_prog = mem[prog_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_we) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [ADDR_W-1:0] ia;
        ia = ADDR_W'(i);
        if (erase_all || (ia[ADDR_W-1:PAGE_W] == erase_page)) mem[i] <= '1;
      end
    end else if (prog_we) begin
      mem[prog_addr] <= prog_merge(old_at_prog, prog_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ok   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ok   <= rd_en && !blocked;
      rd_data <= (rd_en && !blocked) ? mem[rd_addr] : '0;
    end
  end

  // R10
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && blocked) |=> !rd_ok && (rd_data == '0));
  // R5
  and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && !erase_we) |=> ((mem[$past(prog_addr)] & ~$past(old_at_prog)) == '0));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl import flash_seq_pkg::*; #(
  parameter int                ADDR_W   = 11,
  parameter int                PAGE_W   = 6,
  parameter int                PROG_CYC = 30000,
  parameter int                PAGE_CYC = 1000,
  parameter int                MASS_CYC = 4000,
  parameter logic [WORD_W-1:0] KEY_VAL  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_ok,
  output logic              busy,
  output logic              buf_full,
  output logic              cmd_err
);
  localparam int CNT_W  = $clog2(max3(PROG_CYC, PAGE_CYC, MASS_CYC) + 1);
  localparam int ENT_W  = ADDR_W + WORD_W;
  localparam int PG_IDX = ADDR_W - PAGE_W;

  reg_sel_e sel;
  op_e      cmd_op;
  logic     key_wr, cmd_wr, data_wr, addr_wr;
  logic     cmd_accept;

  assign sel     = reg_sel_e'(reg_sel);
  assign cmd_op  = op_e'(reg_wdata[1:0]);
  assign key_wr  = reg_wr && (sel == SEL_KEY);
  assign cmd_wr  = reg_wr && (sel == SEL_CMD);
  assign data_wr = reg_wr && (sel == SEL_DATA);
  assign addr_wr = reg_wr && (sel == SEL_ADDR);

  seq_st_e           state;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] cur_data;
  logic              erase_all_q;
  logic [PG_IDX-1:0] erase_page_q;

  logic             push_ok, buf_empty;
  logic [ENT_W-1:0] head;
  logic             tmr_load, tmr_active, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  // named internal events
  logic launch, prog_we, erase_we, finish_prog;

  assign busy        = (state != ST_IDLE);
  assign launch      = (state == ST_PROG) && (!tmr_active || tmr_done) && !buf_empty;
  assign prog_we     = (state == ST_PROG) && tmr_done;
  assign finish_prog = prog_we && buf_empty;
  assign erase_we    = (state == ST_ERASE) && tmr_done;
  assign tmr_load    = launch || (cmd_accept && (cmd_op != OP_PROG));
  assign tmr_val     = launch             ? CNT_W'(PROG_CYC - 1) :
                       (cmd_op == OP_PAGE) ? CNT_W'(PAGE_CYC - 1) : CNT_W'(MASS_CYC - 1);

  flash_key_gate #(.KEY_VAL(KEY_VAL)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(reg_wdata),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .busy_i(busy),
    .cmd_accept(cmd_accept), .cmd_err(cmd_err)
  );

  flash_word_buffer #(.ENT_W(ENT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(data_wr), .push_data({addr_q, reg_wdata}),
    .pop(launch), .push_ok(push_ok), .head(head), .empty(buf_empty), .full(buf_full)
  );

  flash_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .active(tmr_active), .done(tmr_done)
  );

  flash_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(cur_addr),
    .prog_data(cur_data), .erase_we(erase_we), .erase_all(erase_all_q),
    .erase_page(erase_page_q), .rd_en(rd_en), .rd_addr(rd_addr), .blocked(busy),
    .rd_data(rd_data), .rd_ok(rd_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_wr) begin
      addr_q <= reg_wdata[ADDR_W-1:0];
    end else if (push_ok) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_data <= '0;
    end else if (launch) begin
      {cur_addr, cur_data} <= head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      erase_all_q  <= 1'b0;
      erase_page_q <= '0;
    end else if (cmd_accept) begin
      unique case (cmd_op)
        OP_PROG: state <= ST_PROG;
        OP_PAGE: begin
          state        <= ST_ERASE;
          erase_all_q  <= 1'b0;
          erase_page_q <= addr_q[ADDR_W-1:PAGE_W];
        end
        default: begin
          state       <= ST_ERASE;
          erase_all_q <= 1'b1;
        end
      endcase
    end else if (finish_prog || erase_we) begin
      state <= ST_IDLE;
    end
  end

  // R5
  launch_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> tmr_active && busy);
  // R1
  busy_while_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_active |-> busy);
  // R8
  erase_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> !busy);
  // R7
  prog_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PROG) && !tmr_active && buf_empty) |=> busy);
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
  localparam int AW    = 11;
  localparam int PW    = 6;
  localparam int PROG  = 12;
  localparam int PAGE  = 5;
  localparam int MASS  = 9;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'b00;
  logic [15:0]   reg_wdata = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          rd_ok, busy, buf_full, cmd_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  flash_seq_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .PROG_CYC(PROG), .PAGE_CYC(PAGE),
                   .MASS_CYC(MASS), .KEY_VAL(KEY)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok),
    .busy(busy), .buf_full(buf_full), .cmd_err(cmd_err)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] mm [DEPTH];
  int   q[$];
  int   m_mode, m_cnt, m_ca, m_cd, m_addr, m_page, qn, ent;
  bit   m_puls, m_armed, m_err, m_all, m_done, m_busy_pre;
  bit   m_rd_ok;
  logic [15:0] m_rd_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mm[i] = 16'hFFFF;
      q.delete();
      m_mode = 0; m_cnt = 0; m_puls = 0; m_armed = 0; m_err = 0;
      m_addr = 0; m_rd_ok = 0; m_rd_data = '0;
    end else begin
      m_busy_pre = (m_mode != 0);
      qn = q.size();
      m_rd_ok   = rd_en && !m_busy_pre;
      m_rd_data = m_rd_ok ? mm[rd_addr] : 16'h0000;
      if (m_mode == 1) begin
        m_done = m_puls && (m_cnt == 0);
        if (m_done) mm[m_ca] = mm[m_ca] & m_cd[15:0];
        if ((!m_puls || m_done) && qn > 0) begin
          ent = q.pop_front();
          m_ca = ent >>> 16; m_cd = ent & 32'hFFFF;
          m_cnt = PROG - 1; m_puls = 1;
        end else if (m_done) begin
          m_puls = 0; m_mode = 0;
        end else if (m_puls) m_cnt--;
      end else if (m_mode == 2) begin
        if (m_cnt == 0) begin
          for (int i = 0; i < DEPTH; i++)
            if (m_all || (i / (1 << PW)) == m_page) mm[i] = 16'hFFFF;
          m_mode = 0;
        end else m_cnt--;
      end
      if (reg_wr) begin
        case (reg_sel)
          2'b00: m_armed = (reg_wdata == KEY);
          2'b01: if (!m_busy_pre) begin
            if (m_armed && reg_wdata[1:0] != 2'b00) begin
              m_err = 0;
              if (reg_wdata[1:0] == 2'b01) begin m_mode = 1; m_puls = 0; end
              else begin
                m_mode = 2; m_all = (reg_wdata[1:0] == 2'b11);
                m_cnt = m_all ? MASS - 1 : PAGE - 1;
                m_page = m_addr / (1 << PW);
              end
            end else m_err = 1;
            m_armed = 0;
          end
          2'b10: if (qn < 2) begin
            q.push_back((m_addr << 16) | int'(reg_wdata));
            m_addr = (m_addr + 1) % DEPTH;
          end
          default: m_addr = int'(reg_wdata) % DEPTH;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "model busy", int'(busy), int'(m_mode != 0));
      chk("R4", "model buf_full", int'(buf_full), int'(q.size() == 2));
      chk("R3", "model cmd_err", int'(cmd_err), int'(m_err));
      chk("R10", "model rd_ok", int'(rd_ok), int'(m_rd_ok));
      chk("R10", "model rd_data", int'(rd_data), int'(m_rd_data));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog R1..: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d, output int ok);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data); ok = int'(rd_ok);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
  endtask

  initial begin
    int d, ok, n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "buf_full", int'(buf_full), 0);
    chk("R1", "cmd_err", int'(cmd_err), 0);
    rd(16'h123, d, ok);
    chk("R1", "erased word", d, 16'hFFFF);
    chk("R10", "rd_ok idle", ok, 1);

    // R3 unkeyed command
    wreg(2'b01, 16'h0001);
    chk("R3", "err unkeyed", int'(cmd_err), 1);
    chk("R3", "busy unkeyed", int'(busy), 0);
    // R2 wrong key
    wreg(2'b00, 16'h1234);
    wreg(2'b01, 16'h0002);
    chk("R2", "busy wrong key", int'(busy), 0);
    chk("R2", "err wrong key", int'(cmd_err), 1);

    // R4 buffer fill
    wreg(2'b11, 16'h0010);
    wreg(2'b10, 16'h0F0F);
    wreg(2'b10, 16'h1234);
    chk("R4", "full after two", int'(buf_full), 1);
    wreg(2'b10, 16'h5555);
    chk("R4", "full after refusal", int'(buf_full), 1);

    // R6 two pipelined words
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0001);
    chk("R3", "err cleared", int'(cmd_err), 0);
    busy_len(n);
    chk("R6", "busy two words", n, 2 * PROG + 1);
    rd(16'h010, d, ok); chk("R5", "word0", d, 16'h0F0F);
    rd(16'h011, d, ok); chk("R4", "word1 addr step", d, 16'h1234);
    rd(16'h012, d, ok); chk("R4", "refused word", d, 16'hFFFF);

    // R7 program with empty buffer waits
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0001);
    repeat (20) @(negedge clk);
    chk("R7", "busy empty buffer", int'(busy), 1);
    rd(16'h011, d, ok);
    chk("R10", "blocked rd_ok", ok, 0);
    chk("R10", "blocked rd_data", d, 0);
    // R11 command while busy
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0003);
    chk("R11", "no err busy", int'(cmd_err), 0);
    wreg(2'b11, 16'h0010);
    wreg(2'b10, 16'hFF00);
    wait_idle();
    rd(16'h010, d, ok); chk("R5", "and merge", d, 16'h0F00);
    rd(16'h011, d, ok); chk("R11", "mass ignored", d, 16'h1234);

    // R11 key retained, R5 single word timing
    wreg(2'b11, 16'h0040);
    wreg(2'b10, 16'hAAAA);
    wreg(2'b01, 16'h0001);
    chk("R11", "kept key err", int'(cmd_err), 0);
    busy_len(n);
    chk("R5", "busy one word", n, PROG + 1);

    // R8 page erase
    wreg(2'b11, 16'h0015);
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0002);
    busy_len(n);
    chk("R8", "busy page", n, PAGE);
    rd(16'h010, d, ok); chk("R8", "page word", d, 16'hFFFF);
    rd(16'h011, d, ok); chk("R8", "page word2", d, 16'hFFFF);
    rd(16'h040, d, ok); chk("R8", "other page", d, 16'hAAAA);

    // R2 key consumed
    wreg(2'b01, 16'h0002);
    chk("R2", "consumed err", int'(cmd_err), 1);
    chk("R2", "consumed busy", int'(busy), 0);

    // R9 mass erase
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0003);
    busy_len(n);
    chk("R9", "busy mass", n, MASS);
    rd(16'h040, d, ok); chk("R9", "mass word", d, 16'hFFFF);

    // R3 invalid code
    wreg(2'b00, KEY);
    wreg(2'b01, 16'h0000);
    chk("R3", "invalid code err", int'(cmd_err), 1);
    chk("R3", "invalid code busy", int'(busy), 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule